// File: doc/BRIEF.md
# Parallel USB FIFO Host Sequencer

This block sits between an on-chip byte producer and consumer and an external parallel USB FIFO device that shares the data bus with an external RAM. Bytes offered on the transmit handshake are driven onto the bus and strobed into the device with a positive write pulse. The pulse captures data on its falling edge. A byte is written only after the device reports free space on its active-low space flag, and that flag is sampled again before every byte. When the device reports pending data on its active-low data flag and the consumer is ready, the block pulls the active-low read strobe, samples the bus just before releasing it, and presents the byte with a single-cycle valid pulse.

Every timing window is a clock-cycle count set by a parameter: bus setup before the write pulse, write pulse width, read strobe width and the blanking gap after each access. The two device flags pass through a small synchronizer. During the blanking gap a flag that still shows the state from before the access is not acted on. While the device is being accessed, the block forces the shared RAM select inactive. The bus driver is never enabled while the read strobe is low.

Top module: `usb_fifo_seq`

## Requirements
- R1: While reset is held: dev_rd_no is 1, dev_wr_o is 0, dev_data_oe_o is 0, rx_valid_o is 0 and tx_ready_o is 0.
- R2: A transmit byte is accepted when tx_valid_i and tx_ready_o are both 1 at a clock edge. It is accepted only while dev_txe_ni (space flag, 0 = space free) reads 0. The byte is then driven on dev_data_o with dev_data_oe_o at 1 for exactly SETUP_CYC cycles before dev_wr_o rises.
- R3: dev_wr_o idles at 0 and is high for exactly WR_CYC cycles per byte. dev_data_oe_o stays 1 in the cycle in which dev_wr_o falls. dev_data_o then holds the accepted byte, and bytes reach the device in acceptance order.
- R4: While dev_txe_ni reads 1 (device full), no write pulse is issued. A pending byte is written once the flag returns to 0.
- R5: When dev_rxf_ni (data flag, 0 = data pending) is 0 and rx_ready_i is 1, dev_rd_no goes low for exactly RD_CYC cycles. rx_data_o carries the bus value sampled in the last low cycle, and rx_valid_o is 1 for exactly the one cycle in which dev_rd_no returns high.
- R6: dev_data_oe_o is never 1 while dev_rd_no is 0.
- R7: ram_cs_no is 1 whenever dev_rd_no is 0, dev_wr_o is 1 or dev_data_oe_o is 1. In every other cycle it equals ram_cs_ni.
- R8: Between the end of one device access and the start of the next, at least BLANK_CYC cycles pass with both strobes inactive and the bus released.
- R9: If a read and a transmit byte are both pending in the same idle cycle, the read is performed first.
- R10: While rx_ready_i is 0, no read strobe is issued, even with data pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | DW | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmit byte taken at this edge if valid |
| rx_data_o | output | DW | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse qualifying rx_data_o |
| rx_ready_i | input | 1 | Consumer can take a byte |
| ram_cs_ni | input | 1 | Host RAM select request, active low |
| ram_cs_no | output | 1 | Gated RAM select to the RAM, active low |
| dev_txe_ni | input | 1 | Device space flag, 0 = space free |
| dev_rxf_ni | input | 1 | Device data flag, 0 = data pending |
| dev_rd_no | output | 1 | Device read strobe, active low |
| dev_wr_o | output | 1 | Device write strobe, active high pulse |
| dev_data_i | input | DW | Bus value driven by the device |
| dev_data_o | output | DW | Bus value driven by this block |
| dev_data_oe_o | output | 1 | Bus driver enable |

## Verification
The transmit path is swept through every byte value in an order that changes many bits at a time. This shows whether each value reaches the bus intact and in sequence. A second sweep of all byte values on the receive side separates a wrong sample point from a wrong pulse width. The bench device model holds the space flag busy after each write and then for the whole time its buffer is full. This tells a design that re-samples the flag before each byte apart from one that trusts a stale flag. The model also releases both flags in the same cycle to expose the read-first ordering. A stalled consumer shows whether reads wait for rx_ready_i. The RAM select request toggles throughout, so that gating and pass-through are both seen in every phase.

// File: rtl/usbf_pkg.sv
package usbf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RD,
    ST_BLANK
  } usbf_state_e;
endpackage

// File: rtl/usbf_sync.sv
module usbf_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/usbf_timer.sv
module usbf_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/usbf_bus_gate.sv
module usbf_bus_gate #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          rd_req_i,
  input  logic          wr_pulse_i,
  input  logic          drive_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          ram_cs_ni,
  output logic          ram_cs_no,
  output logic          dev_rd_no,
  output logic          dev_wr_o,
  output logic [DW-1:0] dev_data_o,
  output logic          dev_data_oe_o
);
  // strobes only fire while the device is selected
  assign dev_rd_no     = ~(rd_req_i & sel_i);
  assign dev_wr_o      = wr_pulse_i & sel_i;
  assign dev_data_oe_o = drive_i & sel_i & ~rd_req_i;
  assign dev_data_o    = drive_i ? tx_byte_i : '0;
  assign ram_cs_no     = ram_cs_ni | sel_i;

  assert_rd_oe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dev_rd_no && dev_data_oe_o));

  assert_ram_cs_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rd_no || dev_wr_o || dev_data_oe_o) |-> ram_cs_no);
endmodule

// File: rtl/usb_fifo_seq.sv
module usb_fifo_seq
  import usbf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 2,
  parameter int WR_CYC      = 2,
  parameter int RD_CYC      = 3,
  parameter int BLANK_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  input  logic          ram_cs_ni,
  output logic          ram_cs_no,
  input  logic          dev_txe_ni,
  input  logic          dev_rxf_ni,
  output logic          dev_rd_no,
  output logic          dev_wr_o,
  input  logic [DW-1:0] dev_data_i,
  output logic [DW-1:0] dev_data_o,
  output logic          dev_data_oe_o
);
  localparam int M1   = (SETUP_CYC > WR_CYC) ? SETUP_CYC : WR_CYC;
  localparam int M2   = (RD_CYC > BLANK_CYC) ? RD_CYC : BLANK_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  usbf_state_e state_q, state_d;
  logic txe_s, rxf_s;
  logic tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic rd_go, tx_fire;
  logic [DW-1:0] tx_q, rx_q;
  logic rx_vld_q;

  usbf_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni,
    .d_i({dev_rxf_ni, dev_txe_ni}),
    .q_o({rxf_s, txe_s})
  );

  usbf_timer #(.W(CW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  // read wins over transmit in the same idle cycle
  assign rd_go      = (state_q == ST_IDLE) && !rxf_s && rx_ready_i;
  assign tx_ready_o = (state_q == ST_IDLE) && !txe_s && !rd_go;
  assign tx_fire    = tx_valid_i && tx_ready_o;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_go) begin
          state_d = ST_RD; tmr_load = 1'b1; tmr_val = CW'(RD_CYC - 1);
        end else if (tx_fire) begin
          state_d = ST_WSETUP; tmr_load = 1'b1; tmr_val = CW'(SETUP_CYC - 1);
        end
      end
      ST_WSETUP: if (tmr_done) begin
        state_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = CW'(WR_CYC - 1);
      end
      ST_WPULSE: if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD: begin
        state_d = ST_BLANK; tmr_load = 1'b1; tmr_val = CW'(BLANK_CYC - 1);
      end
      ST_RD: if (tmr_done) begin
        state_d = ST_BLANK; tmr_load = 1'b1; tmr_val = CW'(BLANK_CYC - 1);
      end
      ST_BLANK: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_vld_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rx_vld_q <= (state_q == ST_RD) && tmr_done;
      if (tx_fire) tx_q <= tx_data_i;
      if ((state_q == ST_RD) && tmr_done) rx_q <= dev_data_i;
    end
  end

  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_vld_q;

  usbf_bus_gate #(.DW(DW)) u_gate (
    .clk_i, .rst_ni,
    .sel_i((state_q != ST_IDLE) && (state_q != ST_BLANK)),
    .rd_req_i(state_q == ST_RD),
    .wr_pulse_i(state_q == ST_WPULSE),
    .drive_i(state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD}),
    .tx_byte_i(tx_q),
    .ram_cs_ni, .ram_cs_no,
    .dev_rd_no, .dev_wr_o, .dev_data_o, .dev_data_oe_o
  );

  assert_wr_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_wr_o) |-> $past(dev_data_oe_o) && $stable(dev_data_o));

  assert_wr_fall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_wr_o) |-> dev_data_oe_o && $stable(dev_data_o));

  assert_rx_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_at_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(dev_rd_no));

  assert_post_rd_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rd_no) |=> dev_rd_no && !dev_data_oe_o && !dev_wr_o);

  assert_no_rd_wo_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_rd_no) |-> $past(rx_ready_i));
endmodule

// File: tb/usb_fifo_seq_bench.sv
module usb_fifo_seq_bench;
  localparam int DW = 8, SETUP_CYC = 2, WR_CYC = 2, RD_CYC = 3, BLANK_CYC = 3;
  localparam int TXCAP = 8, REC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [DW-1:0] tx_data_i = '0, rx_data_o, dev_data_o, dev_data_i;
  logic tx_valid_i = 1'b0, tx_ready_o, rx_valid_o, rx_ready_i = 1'b0;
  logic ram_cs_ni = 1'b0, ram_cs_no, dev_txe_ni = 1'b1, dev_rxf_ni = 1'b1;
  logic dev_rd_no, dev_wr_o, dev_data_oe_o;

  usb_fifo_seq #(.DW(DW), .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC),
                 .BLANK_CYC(BLANK_CYC), .SYNC_STAGES(2)) u_usb_fifo_seq (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i, .tx_valid_i, .tx_ready_o,
    .rx_data_o, .rx_valid_o, .rx_ready_i, .ram_cs_ni, .ram_cs_no,
    .dev_txe_ni, .dev_rxf_ni, .dev_rd_no, .dev_wr_o, .dev_data_i,
    .dev_data_o, .dev_data_oe_o);

  int n_run = 0, n_fail = 0, cyc = 0;
  int tx_idx = 0, tx_chk = 0, rx_chk = 0, rx_head = 0, rx_tail = 0;
  int tx_fill = 0, txe_rec = 0, rx_rec = 0, n_wr = 0, n_rd = 0;
  int setup_run = 0, wr_run = 0, rd_run = 0, idle_run = 0;
  bit drain_en = 1'b0, txe_block = 1'b0, rxf_block = 1'b0, seen = 1'b0, done = 1'b0;
  bit prev_act = 1'b0, prev_wr = 1'b0, prev_rd_n = 1'b1, prev_rxv = 1'b0;
  bit arm = 1'b0, first_is_rd = 1'b0, first_seen = 1'b0;

  function automatic logic [7:0] tx_val(int i); return 8'((i * 53 + 11) & 255); endfunction
  function automatic logic [7:0] rx_val(int i); return 8'((i * 37 + 5) & 255); endfunction

  assign dev_data_i = dev_rd_no ? 8'h00 : rx_val(rx_head);

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // device model and port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit act;
      act = dev_data_oe_o || !dev_rd_no || dev_wr_o;
      if (act) chk(ram_cs_no == 1'b1, "R7", ram_cs_no, 1);
      else     chk(ram_cs_no == ram_cs_ni, "R7", ram_cs_no, ram_cs_ni);
      if (act && !prev_act) begin
        if (seen) chk(idle_run >= BLANK_CYC, "R8", idle_run, BLANK_CYC);
        seen = 1'b1;
        if (arm && !first_seen) begin first_seen = 1'b1; first_is_rd = !dev_rd_no; end
      end
      if (txe_rec > 0) txe_rec--;
      if (rx_rec > 0) rx_rec--;
      if (drain_en && tx_fill > 0 && (cyc % 4 == 0)) tx_fill--;
      if (dev_wr_o && !prev_wr) chk(setup_run == SETUP_CYC, "R2", setup_run, SETUP_CYC);
      if (!dev_wr_o && prev_wr) begin
        chk(wr_run == WR_CYC, "R3 width", wr_run, WR_CYC);
        chk(dev_data_oe_o && dev_data_o == tx_val(tx_chk), "R3 data", dev_data_o, tx_val(tx_chk));
        chk(tx_fill < TXCAP, "R4", tx_fill, TXCAP - 1);
        tx_chk++; n_wr++; tx_fill++; txe_rec = REC;
      end
      if (!dev_rd_no && prev_rd_n) begin
        chk(!dev_data_oe_o, "R6", dev_data_oe_o, 0);
        chk(rx_ready_i, "R10", rx_ready_i, 1);
        n_rd++; rx_rec = REC;
      end
      if (dev_rd_no && !prev_rd_n) begin
        chk(rd_run == RD_CYC, "R5 width", rd_run, RD_CYC);
        rx_head++;
      end
      if (rx_valid_o) begin
        chk(!prev_rxv, "R5 pulse", prev_rxv, 0);
        chk(rx_data_o == rx_val(rx_chk), "R5 data", rx_data_o, rx_val(rx_chk));
        rx_chk++;
      end
      setup_run = (dev_data_oe_o && !dev_wr_o) ? setup_run + 1 : 0;
      wr_run    = dev_wr_o ? wr_run + 1 : 0;
      rd_run    = !dev_rd_no ? rd_run + 1 : 0;
      idle_run  = act ? 0 : idle_run + 1;
      prev_act = act; prev_wr = dev_wr_o; prev_rd_n = dev_rd_no; prev_rxv = rx_valid_o;
    end
    dev_txe_ni <= txe_block || txe_rec != 0 || tx_fill >= TXCAP;
    dev_rxf_ni <= rxf_block || rx_rec != 0 || rx_head >= rx_tail;
    ram_cs_ni  <= (cyc % 3 == 0);
  end

  task automatic send_pending();
    tx_valid_i = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
    tx_idx++;
  endtask

  task automatic send();
    tx_data_i = tx_val(tx_idx);
    send_pending();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int nw, nr;
    repeat (3) @(negedge clk);
    chk(dev_rd_no == 1'b1, "R1 rd", dev_rd_no, 1);
    chk(dev_wr_o == 1'b0, "R1 wr", dev_wr_o, 0);
    chk(dev_data_oe_o == 1'b0, "R1 oe", dev_data_oe_o, 0);
    chk(rx_valid_o == 1'b0, "R1 rxv", rx_valid_o, 0);
    chk(tx_ready_o == 1'b0, "R1 rdy", tx_ready_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R3: all byte values out
    drain_en = 1'b1;
    for (int i = 0; i < 256; i++) send();
    while (tx_chk < 256) @(negedge clk);
    chk(tx_chk == 256, "R3 count", tx_chk, 256);

    // R5: all byte values in
    rx_ready_i = 1'b1;
    rx_tail = 256;
    while (rx_chk < 256) @(negedge clk);
    chk(rx_chk == 256, "R5 count", rx_chk, 256);

    // R10: consumer stalled
    rx_ready_i = 1'b0;
    repeat (20) @(negedge clk);
    nr = n_rd;
    rx_tail = 258;
    repeat (40) @(negedge clk);
    chk(n_rd == nr, "R10", n_rd, nr);
    chk(rx_chk == 256, "R10 rxv", rx_chk, 256);
    rx_ready_i = 1'b1;
    while (rx_chk < 258) @(negedge clk);
    chk(n_rd == nr + 2, "R10 resume", n_rd, nr + 2);

    // R4: device full
    while (tx_fill > 0) @(negedge clk);
    drain_en = 1'b0;
    for (int i = 0; i < TXCAP; i++) send();
    repeat (10) @(negedge clk);
    nw = n_wr;
    tx_data_i = tx_val(tx_idx);
    tx_valid_i = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_wr == nw, "R4 full", n_wr, nw);
    drain_en = 1'b1;
    send_pending();
    while (tx_chk < tx_idx) @(negedge clk);
    chk(n_wr == nw + 1, "R4 resume", n_wr, nw + 1);

    // R9: read and write pending together
    txe_block = 1'b1; rxf_block = 1'b1;
    repeat (20) @(negedge clk);
    rx_tail = 259;
    tx_data_i = tx_val(tx_idx);
    tx_valid_i = 1'b1;
    repeat (10) @(negedge clk);
    arm = 1'b1;
    txe_block = 1'b0; rxf_block = 1'b0;
    send_pending();
    while (tx_chk < tx_idx || rx_chk < 259) @(negedge clk);
    chk(first_seen && first_is_rd, "R9", first_is_rd, 1);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule